// File: doc/BRIEF.md
# Sampling Program-Counter Histogram Profiler

This block counts retired instructions and, once every programmable number of retirements, takes the program counter of the instruction retiring at that moment as a sample. The sample selects a bin in an internal histogram (the PC shifted right by a fixed amount), and that bin's counter is incremented. Counters stop at a fixed ceiling instead of wrapping. Samples whose bin would lie beyond the histogram are discarded.

Each time a sample is taken, the running total of retired instructions is compared against a programmable limit. Passing that limit raises a sticky flag that a run controller can use to stop a runaway program. Software dumps the histogram through a registered read port. A one-cycle clear request sweeps every bin to zero, one bin per clock, while a busy output stays high.

Top module: `prof_hist`

## Requirements
- R1: After reset, `timeoutHit` and `clearBusy` are low and every bin reads zero.
- R2: Each cycle with `retireValid` high adds one to a retirement counter. When the counter reaches the effective period, a sample is taken and the period is subtracted from the counter. With period P, samples fall on retirements P, 2P, 3P and so on.
- R3: The bin index of a sample is `retirePc >> PC_SHIFT`. With the default shift of 2, the two low PC bits do not affect the bin.
- R4: A sample whose index is not below 2^BIN_BITS changes no bin. Index 2^BIN_BITS-1 is still counted.
- R5: A bin that holds SAT_MAX is not incremented further (default 65000, 16-bit bins).
- R6: While `profEn` is low, the effective period is all ones, so no sample is taken within 2^CNT_W-2 retirements.
- R7: When a sample is taken and the total number of retirements since reset (including the current one) exceeds `timeoutLimit`, `timeoutHit` goes high at that edge and stays high until reset. It is never set between samples.
- R8: `rdData` shows the value of bin `rdAddr` one clock after the address is presented. If that bin is incremented at the same edge, the value before the increment is returned.
- R9: A `clearReq` pulse seen while idle raises `clearBusy` for exactly 2^BIN_BITS cycles and zeros every bin. Samples taken while `clearBusy` or `clearReq` is high are discarded. `clearReq` during a sweep is ignored.
- R10: A programmed period of zero behaves as a period of one.
- R11: Cycles with `retireValid` low do not advance the retirement counter.
- R12: The increment from a sample lands on the clock edge after the retirement edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| retireValid | input | 1 | An instruction retires this cycle |
| retirePc | input | PC_W | PC of the retiring instruction |
| profEn | input | 1 | Enables sampling; when low, the period is forced to all ones |
| samplePeriod | input | CNT_W | Retirements between samples (0 treated as 1) |
| timeoutLimit | input | ACC_W | Retirement total that, once exceeded at a sample, raises the flag |
| clearReq | input | 1 | Starts a bin-clearing sweep |
| rdAddr | input | BIN_BITS | Bin to read |
| rdData | output | BIN_W | Registered bin value |
| clearBusy | output | 1 | Clearing sweep in progress |
| timeoutHit | output | 1 | Sticky timeout flag |

## Verification
The bench builds the profiler with 16 bins (BIN_BITS=4), a ceiling of 12 and a 16-bit retirement counter. Saturation, the full clear sweep and the out-of-range boundary (index 15 counted, index 16 dropped) are then reached in a few dozen cycles. The 16-bit counter keeps the all-ones period of disabled profiling meaningful for the run length. A cycle-by-cycle model tracks every bin, the pending increment, the sweep and the timeout total, and the bench compares the read port, busy flag and timeout flag against it on every clock. Directed sequences add checks on the period arithmetic, the same-edge read ordering and the timeout falling only on sample edges.

// File: rtl/prof_hist_pkg.sv
package prof_hist_pkg;

  // Write strobes from the control side to the bin storage.
  typedef struct packed {
    logic incEn;   // increment the bin addressed by incIdx
    logic clrEn;   // zero the bin addressed by clrIdx
  } binStrobe_t;

endpackage

// File: rtl/prof_clr_seq.sv
module prof_clr_seq #(
  parameter int BIN_BITS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clearReq,
  output logic                clearBusy,
  output logic [BIN_BITS-1:0] clrIdx
);

  localparam logic [BIN_BITS-1:0] LAST_IDX = '1;

  // One bin per clock; a request during a sweep is ignored.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clearBusy <= 1'b0;
      clrIdx    <= '0;
    end else if (clearReq && !clearBusy) begin
      clearBusy <= 1'b1;
      clrIdx    <= '0;
    end else if (clearBusy) begin
      if (clrIdx == LAST_IDX) clearBusy <= 1'b0;
      clrIdx <= clrIdx + 1'b1;
    end
  end

endmodule

// File: rtl/prof_ctrl.sv
module prof_ctrl
  import prof_hist_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int PC_SHIFT = 2,
  parameter int BIN_BITS = 8,
  parameter int CNT_W    = 32,
  parameter int ACC_W    = 48
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                retireValid,
  input  logic [PC_W-1:0]     retirePc,
  input  logic                profEn,
  input  logic [CNT_W-1:0]    samplePeriod,
  input  logic [ACC_W-1:0]    timeoutLimit,
  input  logic                clearReq,
  output binStrobe_t          strb,
  output logic [BIN_BITS-1:0] incIdx,
  output logic [BIN_BITS-1:0] clrIdx,
  output logic                clearBusy,
  output logic                timeoutHit
);

  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    cntNext;
  logic [CNT_W-1:0]    periodEff;
  logic [ACC_W-1:0]    accum;
  logic [ACC_W:0]      runNext;
  logic [PC_W-1:0]     pcIdx;
  logic                sampleHit;
  logic                inRange;
  logic                incEnQ;
  logic [BIN_BITS-1:0] incIdxQ;

  // Disabled profiling pushes the period out of reach; zero acts as one.
  always_comb begin
    if (!profEn)                 periodEff = '1;
    else if (samplePeriod == '0) periodEff = CNT_W'(1);
    else                         periodEff = samplePeriod;
  end

  // cnt stays below periodEff, so cntNext cannot wrap.
  assign cntNext   = cnt + CNT_W'(1);
  assign sampleHit = retireValid && (cntNext >= periodEff);
  assign runNext   = {1'b0, accum} + (ACC_W+1)'(cntNext);
  assign pcIdx     = retirePc >> PC_SHIFT;
  assign inRange   = (pcIdx >> BIN_BITS) == '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt        <= '0;
      accum      <= '0;
      timeoutHit <= 1'b0;
    end else if (retireValid) begin
      if (sampleHit) begin
        cnt   <= cntNext - periodEff;
        accum <= accum + ACC_W'(periodEff);
        if (runNext > {1'b0, timeoutLimit}) timeoutHit <= 1'b1;
      end else begin
        cnt <= cntNext;
      end
    end
  end

  // Sample stage: the increment reaches the bins one edge later.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      incEnQ  <= 1'b0;
      incIdxQ <= '0;
    end else begin
      incEnQ  <= sampleHit && inRange && !clearBusy && !clearReq;
      incIdxQ <= pcIdx[BIN_BITS-1:0];
    end
  end

  prof_clr_seq #(.BIN_BITS(BIN_BITS)) u_clr_seq (
    .clk      (clk),
    .rstN     (rstN),
    .clearReq (clearReq),
    .clearBusy(clearBusy),
    .clrIdx   (clrIdx)
  );

  assign strb.incEn = incEnQ;
  assign strb.clrEn = clearBusy;
  assign incIdx     = incIdxQ;

endmodule

// File: rtl/prof_bins.sv
module prof_bins
  import prof_hist_pkg::*;
#(
  parameter int BIN_BITS = 8,
  parameter int BIN_W    = 16,
  parameter int SAT_MAX  = 65000
) (
  input  logic                clk,
  input  logic                rstN,
  input  binStrobe_t          strb,
  input  logic [BIN_BITS-1:0] incIdx,
  input  logic [BIN_BITS-1:0] clrIdx,
  input  logic [BIN_BITS-1:0] rdAddr,
  output logic [BIN_W-1:0]    rdData
);

  localparam int              NUM_BINS = 1 << BIN_BITS;
  localparam logic [BIN_W-1:0] CEIL    = BIN_W'(SAT_MAX);

  logic [BIN_W-1:0] binVec [NUM_BINS];

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    logic [BIN_W-1:0] val;
    logic             hitClr;
    logic             hitInc;

    assign hitClr = strb.clrEn && (clrIdx == BIN_BITS'(b));
    assign hitInc = strb.incEn && (incIdx == BIN_BITS'(b));

    // Clearing wins; a bin at the ceiling holds its value.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                       val <= '0;
      else if (hitClr)                 val <= '0;
      else if (hitInc && (val < CEIL)) val <= val + 1'b1;
    end

    assign binVec[b] = val;
  end

  // Registered read returns the pre-edge contents.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= binVec[rdAddr];
  end

endmodule

// File: rtl/prof_hist.sv
module prof_hist
  import prof_hist_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int PC_SHIFT = 2,
  parameter int BIN_BITS = 8,
  parameter int BIN_W    = 16,
  parameter int SAT_MAX  = 65000,
  parameter int CNT_W    = 32,
  parameter int ACC_W    = 48
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                retireValid,
  input  logic [PC_W-1:0]     retirePc,
  input  logic                profEn,
  input  logic [CNT_W-1:0]    samplePeriod,
  input  logic [ACC_W-1:0]    timeoutLimit,
  input  logic                clearReq,
  input  logic [BIN_BITS-1:0] rdAddr,
  output logic [BIN_W-1:0]    rdData,
  output logic                clearBusy,
  output logic                timeoutHit
);

  binStrobe_t          strb;
  logic [BIN_BITS-1:0] incIdx;
  logic [BIN_BITS-1:0] clrIdx;

  prof_ctrl #(
    .PC_W(PC_W), .PC_SHIFT(PC_SHIFT), .BIN_BITS(BIN_BITS),
    .CNT_W(CNT_W), .ACC_W(ACC_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .retireValid (retireValid),
    .retirePc    (retirePc),
    .profEn      (profEn),
    .samplePeriod(samplePeriod),
    .timeoutLimit(timeoutLimit),
    .clearReq    (clearReq),
    .strb        (strb),
    .incIdx      (incIdx),
    .clrIdx      (clrIdx),
    .clearBusy   (clearBusy),
    .timeoutHit  (timeoutHit)
  );

  prof_bins #(
    .BIN_BITS(BIN_BITS), .BIN_W(BIN_W), .SAT_MAX(SAT_MAX)
  ) u_bins (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .incIdx(incIdx),
    .clrIdx(clrIdx),
    .rdAddr(rdAddr),
    .rdData(rdData)
  );

endmodule

// File: rtl/prof_hist_chk.sv
module prof_hist_chk #(
  parameter int NUM_BINS = 256,
  parameter int BIN_W    = 16,
  parameter int SAT_MAX  = 65000
) (
  input logic             clk,
  input logic             rstN,
  input logic             retireValid,
  input logic             clearReq,
  input logic             clearBusy,
  input logic             timeoutHit,
  input logic [BIN_W-1:0] rdData
);

  int busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          busyRun <= 0;
    else if (clearBusy) busyRun <= busyRun + 1;
    else                busyRun <= 0;
  end

  // R7: the flag never drops once set
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    timeoutHit |=> timeoutHit);

  // R7: the flag only rises on an edge that saw a retirement
  a_r7_on_retire: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutHit) |-> $past(retireValid));

  // R9: an idle clear request starts a sweep
  a_r9_sweep_start: assert property (@(posedge clk) disable iff (!rstN)
    (clearReq && !clearBusy) |=> clearBusy);

  // R9: a sweep lasts no more than one cycle per bin
  a_r9_sweep_len: assert property (@(posedge clk) disable iff (!rstN)
    clearBusy |-> (busyRun < NUM_BINS));

  // R5: no value read back exceeds the ceiling
  a_r5_ceiling: assert property (@(posedge clk) disable iff (!rstN)
    rdData <= BIN_W'(SAT_MAX));

endmodule

bind prof_hist prof_hist_chk #(
  .NUM_BINS(1 << BIN_BITS), .BIN_W(BIN_W), .SAT_MAX(SAT_MAX)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .retireValid(retireValid),
  .clearReq   (clearReq),
  .clearBusy  (clearBusy),
  .timeoutHit (timeoutHit),
  .rdData     (rdData)
);

// File: tb/prof_hist_bench.sv
module prof_hist_bench;

  localparam int CLK_PERIOD = 10;
  localparam int BB    = 4;
  localparam int NB    = 1 << BB;
  localparam int SAT   = 12;
  localparam int CW    = 16;
  localparam int AW    = 24;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          retireValid = 1'b0;
  logic [31:0]   retirePc = '0;
  logic          profEn = 1'b1;
  logic [CW-1:0] samplePeriod = CW'(1);
  logic [AW-1:0] timeoutLimit = '1;
  logic          clearReq = 1'b0;
  logic [BB-1:0] rdAddr = '0;
  logic [15:0]   rdData;
  logic          clearBusy;
  logic          timeoutHit;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prof_hist #(
    .PC_W(32), .PC_SHIFT(2), .BIN_BITS(BB), .BIN_W(16),
    .SAT_MAX(SAT), .CNT_W(CW), .ACC_W(AW)
  ) u_prof_hist (
    .clk(clk), .rstN(rstN), .retireValid(retireValid), .retirePc(retirePc),
    .profEn(profEn), .samplePeriod(samplePeriod), .timeoutLimit(timeoutLimit),
    .clearReq(clearReq), .rdAddr(rdAddr), .rdData(rdData),
    .clearBusy(clearBusy), .timeoutHit(timeoutHit)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int     mB [NB];
  int     mCnt, mClr, pendI, mExp;
  longint mAcc;
  bit     mBusy, mTo, pendV;

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mB[i]) mB[i] = 0;
      mCnt = 0; mClr = 0; pendI = 0; mExp = 0;
      mAcc = 0; mBusy = 0; mTo = 0; pendV = 0;
    end else begin
      longint per;
      longint c;
      longint idx;
      mExp = mB[rdAddr];
      if (pendV && !(mBusy && mClr == pendI) && mB[pendI] < SAT) mB[pendI]++;
      if (mBusy) mB[mClr] = 0;
      pendV = 0;
      per = !profEn ? longint'((1 << CW) - 1) :
            (samplePeriod == 0 ? 1 : longint'(samplePeriod));
      if (retireValid) begin
        c = mCnt + 1;
        if (c >= per) begin
          if (mAcc + c > longint'(timeoutLimit)) mTo = 1;
          mAcc += per;
          mCnt = int'(c - per);
          idx = longint'(retirePc >> 2);
          if (idx < NB && !mBusy && !clearReq) begin
            pendV = 1;
            pendI = int'(idx);
          end
        end else begin
          mCnt = int'(c);
        end
      end
      if (clearReq && !mBusy) begin
        mBusy = 1; mClr = 0;
      end else if (mBusy) begin
        if (mClr == NB - 1) mBusy = 0;
        mClr = (mClr + 1) % NB;
      end
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rstN) begin
      chk("R8 rdData vs model", rdData, mExp);
      chk("R9 clearBusy vs model", clearBusy, mBusy);
      chk("R7 timeoutHit vs model", timeoutHit, mTo);
    end
  end

  // ---------------- stimulus helpers (start and end at negedge) ----------------
  task automatic doReset();
    rstN = 1'b0;
    retireValid = 1'b0;
    clearReq = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doRetire(input logic [31:0] pc, input int n);
    for (int i = 0; i < n; i++) begin
      retireValid = 1'b1;
      retirePc = pc;
      @(negedge clk);
    end
    retireValid = 1'b0;
  endtask

  task automatic readBin(input int idx, output int val);
    rdAddr = BB'(idx);
    @(negedge clk);
    val = int'(rdData);
  endtask

  // Expect one bin at a value and all others at zero.
  task automatic expectBins(input string tag, input int bin, input int val);
    int v;
    int bad;
    bad = 0;
    idle(2);
    for (int i = 0; i < NB; i++) begin
      readBin(i, v);
      if (v != ((i == bin) ? val : 0)) bad++;
    end
    chk({tag, " other bins zero"}, bad, 0);
    readBin(bin, v);
    chk(tag, v, val);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=hung expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int v;
    int n;
    doReset();
    // R1: reset state
    chk("R1 timeoutHit after reset", timeoutHit, 0);
    chk("R1 clearBusy after reset", clearBusy, 0);
    expectBins("R1 bins zero after reset", 0, 0);

    // R2 / R3: period 3, low PC bits vary, all map to bin 2
    samplePeriod = CW'(3);
    for (int i = 0; i < 9; i++) doRetire(32'h8 + 32'(i % 4), 1);
    expectBins("R2 R3 bin2 after 9 retires period 3", 2, 3);

    // R11: idle cycles do not count
    doReset();
    samplePeriod = CW'(2);
    doRetire(32'hC, 1);
    idle(5);
    doRetire(32'hC, 2);
    expectBins("R11 bin3 with idle gaps period 2", 3, 1);

    // R4: out of range dropped, top bin counted
    doReset();
    samplePeriod = CW'(1);
    doRetire(32'h1000, 5);
    doRetire(32'h40, 3);
    doRetire(32'h3C, 2);
    expectBins("R4 only bin15 counted", 15, 2);

    // R5: saturation at ceiling
    doReset();
    samplePeriod = CW'(1);
    doRetire(32'h4, 20);
    expectBins("R5 bin1 saturates", 1, SAT);

    // R10: period zero acts as one
    doReset();
    samplePeriod = '0;
    doRetire(32'h18, 4);
    expectBins("R10 bin6 period zero", 6, 4);

    // R6: disabled profiling takes no samples
    doReset();
    profEn = 1'b0;
    samplePeriod = CW'(1);
    doRetire(32'h1C, 50);
    expectBins("R6 disabled no samples", 7, 0);
    profEn = 1'b1;

    // R12 / R8: increment lands one edge late; same-edge read sees old value
    doReset();
    samplePeriod = CW'(1);
    rdAddr = BB'(5);
    doRetire(32'h14, 1);
    chk("R12 bin5 not yet incremented", rdData, 0);
    @(negedge clk);
    chk("R8 read on increment edge returns old value", rdData, 0);
    @(negedge clk);
    chk("R8 read after increment edge", rdData, 1);

    // R9: clear sweep, dropped samples, resume afterwards
    doReset();
    samplePeriod = CW'(1);
    doRetire(32'h20, 3);
    idle(2);
    clearReq = 1'b1;
    @(negedge clk);
    clearReq = 1'b0;
    retireValid = 1'b1;
    retirePc = 32'h24;
    n = 0;
    while (clearBusy && n < 100) begin
      n++;
      @(negedge clk);
    end
    retireValid = 1'b0;
    chk("R9 busy length", n, NB);
    expectBins("R9 all bins cleared, busy-time samples dropped", 8, 0);
    doRetire(32'h24, 1);
    expectBins("R9 sampling resumes after sweep", 9, 1);

    // R7: timeout only at a sample edge, then sticky
    doReset();
    samplePeriod = CW'(4);
    timeoutLimit = AW'(10);
    doRetire(32'h1000, 11);
    idle(2);
    chk("R7 not set between samples", timeoutHit, 0);
    doRetire(32'h1000, 1);
    chk("R7 set at sample past limit", timeoutHit, 1);
    timeoutLimit = '1;
    idle(3);
    chk("R7 stays set", timeoutHit, 1);
    readBin(0, v);
    chk("R4 out-of-range samples left bin0", v, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule